// File: doc/BRIEF.md
# Cyclic Prefix Insertion Buffer

This block sits after a streaming inverse FFT in an OFDM transmitter. It accepts time-domain symbols of `N_FFT` complex samples, one sample per handshake, and sends each one out again as an extended symbol of `N_FFT + N_CP` samples. The extended symbol starts with a guard interval, which is a copy of the final `N_CP` input samples. The complete symbol follows in its original order. With the defaults (64 and 16) the guard interval lasts 0.8 us at a 20 MHz sample rate.

The block stores the guard samples and the symbol body in separate memories. Each memory has two banks, so the next symbol can be written while the previous one is being read out. Both sides of the block use valid/ready streaming handshakes. The output also carries a start-of-symbol flag and a last-sample flag. Each input symbol of 64 samples produces 80 output samples, so a steady input stream is paced by the read side through back-pressure.

Top module: `cp_insert`

## Requirements
- R1: Every extended output symbol is `N_FFT+N_CP` (80) accepted output samples. `out_sos` is high on output position 0 only, and `out_last` is high on position 79 only.
- R2: Output positions 0..15 carry input samples 48..63 of the same symbol, in that order.
- R3: Output positions 16..79 carry input samples 0..63 of the same symbol, in order.
- R4: After reset, `out_valid` stays low until 64 input samples have been accepted. It goes high in the cycle after the 64th acceptance.
- R5: When two captured symbols are still unsent, `in_ready` is low and no input is accepted.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high, and `out_re`, `out_im`, `out_sos` and `out_last` are unchanged.
- R7: While at most one captured symbol is unsent, `in_ready` is high. Capturing the next symbol therefore overlaps with sending the current one.
- R8: Synchronous reset (`rst` high) discards all buffered symbols. In the cycle after reset, `out_valid` is low and `in_ready` is high.
- R9: Extended symbols leave in the same order their input symbols were captured, and none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_re | input | DW | Input sample, real part |
| in_im | input | DW | Input sample, imaginary part |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_re | output | DW | Output sample, real part |
| out_im | output | DW | Output sample, imaginary part |
| out_sos | output | 1 | First sample of an extended symbol |
| out_last | output | 1 | Final sample of an extended symbol |

## Verification
A directed phase fills the block while the output is held off. This shows the exact cycle in which the first symbol becomes readable, that a second symbol can be captured while the first waits, that input stops at two symbols, and that a stalled output holds steady. Random phases then vary how dense input-valid and output-ready are: both saturated, sparse input, sparse output, and both medium. Sparse input exposes bank hand-off while the read side waits. Sparse output exposes back-pressure and holding during stalls. Every output sample is compared with its expected value, so a guard taken from the wrong indices, a body that is shifted, or swapped banks shows up as a data mismatch. A final reset in the middle of a stream shows that buffered symbols are dropped and that capture restarts cleanly.

// File: rtl/cp_pkg.sv
package cp_pkg;

    // Width of the position counters; must hold N_FFT + N_CP - 1.
    localparam int POS_W = 8;

    // Bank selector plus position inside the symbol.
    typedef struct packed {
        logic             bank;
        logic [POS_W-1:0] idx;
    } cp_ptr_t;

endpackage

// File: rtl/cp_sample_ram.sv
// Two-bank sample store: one write port, one asynchronous read port.
module cp_sample_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                mem_q[wr_addr] <= wr_data;
            end
        end

        assign bank_rd[b] = mem_q[rd_addr];
    end

    assign rd_data = rd_bank ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/cp_bank_track.sv
// Occupancy flag per bank: set when a symbol is fully written, cleared when fully sent.
module cp_bank_track (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_done,
    input  logic       wr_bank,
    input  logic       rd_done,
    input  logic       rd_bank,
    output logic [1:0] bank_full
);

    logic [1:0] full_d, full_q;

    always_comb begin
        full_d = full_q;
        if (rd_done) begin
            full_d[rd_bank] = 1'b0;
        end
        if (wr_done) begin
            full_d[wr_bank] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= '0;
        end else begin
            full_q <= full_d;
        end
    end

    assign bank_full = full_q;

endmodule

// File: rtl/cp_wr_ctrl.sv
// Write side: walks 0..N_FFT-1 in the free bank, then hands the bank over.
module cp_wr_ctrl import cp_pkg::*; #(
    parameter int N_FFT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       bank_full,
    output logic             in_ready,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [POS_W-1:0] wr_idx,
    output logic             wr_done
);

    localparam logic [POS_W-1:0] LAST_IDX = POS_W'(N_FFT - 1);

    cp_ptr_t st_d, st_q;
    logic    fire;

    always_comb begin
        st_d = st_q;
        fire = in_valid && !bank_full[st_q.bank];
        if (fire) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.idx  = '0;
                st_d.bank = ~st_q.bank;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = !bank_full[st_q.bank];
    assign wr_en    = fire;
    assign wr_bank  = st_q.bank;
    assign wr_idx   = st_q.idx;
    assign wr_done  = fire && (st_q.idx == LAST_IDX);

endmodule

// File: rtl/cp_rd_ctrl.sv
// Read side: walks 0..N_FFT+N_CP-1 over a full bank, then releases it.
module cp_rd_ctrl import cp_pkg::*; #(
    parameter int N_FFT = 64,
    parameter int N_CP  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_ready,
    input  logic [1:0]       bank_full,
    output logic             out_valid,
    output logic             rd_bank,
    output logic [POS_W-1:0] rd_pos,
    output logic             rd_done,
    output logic             sos,
    output logic             last
);

    localparam int               N_TOT    = N_FFT + N_CP;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_TOT - 1);

    cp_ptr_t st_d, st_q;
    logic    fire;

    always_comb begin
        st_d = st_q;
        fire = bank_full[st_q.bank] && out_ready;
        if (fire) begin
            if (st_q.idx == LAST_POS) begin
                st_d.idx  = '0;
                st_d.bank = ~st_q.bank;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = bank_full[st_q.bank];
    assign rd_bank   = st_q.bank;
    assign rd_pos    = st_q.idx;
    assign rd_done   = fire && (st_q.idx == LAST_POS);
    assign sos       = (st_q.idx == '0);
    assign last      = (st_q.idx == LAST_POS);

endmodule

// File: rtl/cp_insert.sv
// Guard-interval inserter: N_FFT samples in, N_CP + N_FFT samples out.
module cp_insert import cp_pkg::*; #(
    parameter int DW    = 16,
    parameter int N_FFT = 64,
    parameter int N_CP  = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_re,
    input  logic [DW-1:0] in_im,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im,
    output logic          out_sos,
    output logic          out_last
);

    localparam int SW      = 2 * DW;
    localparam int BODY_AW = $clog2(N_FFT);
    localparam int CP_AW   = $clog2(N_CP);
    localparam int CP_OFF  = N_FFT - N_CP;

    logic [1:0]         bank_full;
    logic               wr_en, wr_bank, wr_done;
    logic [POS_W-1:0]   wr_idx;
    logic               rd_bank, rd_done, rd_sos, rd_last;
    logic [POS_W-1:0]   rd_pos;
    logic               in_guard, rd_in_guard;
    logic [CP_AW-1:0]   guard_wr_addr, guard_rd_addr;
    logic [BODY_AW-1:0] body_wr_addr, body_rd_addr;
    logic [SW-1:0]      wr_data, guard_rd_data, body_rd_data, rd_data;

    cp_wr_ctrl #(.N_FFT(N_FFT)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .bank_full(bank_full),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_idx   (wr_idx),
        .wr_done  (wr_done)
    );

    cp_rd_ctrl #(.N_FFT(N_FFT), .N_CP(N_CP)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .out_ready(out_ready),
        .bank_full(bank_full),
        .out_valid(out_valid),
        .rd_bank  (rd_bank),
        .rd_pos   (rd_pos),
        .rd_done  (rd_done),
        .sos      (rd_sos),
        .last     (rd_last)
    );

    cp_bank_track u_track (
        .clk      (clk),
        .rst      (rst),
        .wr_done  (wr_done),
        .wr_bank  (wr_bank),
        .rd_done  (rd_done),
        .rd_bank  (rd_bank),
        .bank_full(bank_full)
    );

    // Write addressing: tail samples also land in the guard store.
    assign wr_data       = {in_re, in_im};
    assign in_guard      = (wr_idx >= POS_W'(CP_OFF));
    assign guard_wr_addr = CP_AW'(wr_idx - POS_W'(CP_OFF));
    assign body_wr_addr  = BODY_AW'(wr_idx);

    // Read addressing: guard first, then the whole body.
    assign rd_in_guard   = (rd_pos < POS_W'(N_CP));
    assign guard_rd_addr = CP_AW'(rd_pos);
    assign body_rd_addr  = BODY_AW'(rd_pos - POS_W'(N_CP));

    cp_sample_ram #(.W(SW), .DEPTH(N_CP)) u_guard_ram (
        .clk    (clk),
        .wr_en  (wr_en && in_guard),
        .wr_bank(wr_bank),
        .wr_addr(guard_wr_addr),
        .wr_data(wr_data),
        .rd_bank(rd_bank),
        .rd_addr(guard_rd_addr),
        .rd_data(guard_rd_data)
    );

    cp_sample_ram #(.W(SW), .DEPTH(N_FFT)) u_body_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_bank(wr_bank),
        .wr_addr(body_wr_addr),
        .wr_data(wr_data),
        .rd_bank(rd_bank),
        .rd_addr(body_rd_addr),
        .rd_data(body_rd_data)
    );

    assign rd_data  = rd_in_guard ? guard_rd_data : body_rd_data;
    assign out_re   = rd_data[SW-1:DW];
    assign out_im   = rd_data[DW-1:0];
    assign out_sos  = out_valid && rd_sos;
    assign out_last = out_valid && rd_last;

endmodule

// File: rtl/cp_insert_chk.sv
module cp_insert_chk #(
    parameter int DW    = 16,
    parameter int N_FFT = 64,
    parameter int N_CP  = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_re,
    input logic [DW-1:0] out_im,
    input logic          out_sos,
    input logic          out_last
);

    localparam int N_TOT = N_FFT + N_CP;

    int   in_cnt_q, out_pos_q, occ_q;
    logic rst_seen_q;
    logic in_fire, out_fire, sym_in, sym_out;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign sym_in   = in_fire && (in_cnt_q == N_FFT - 1);
    assign sym_out  = out_fire && (out_pos_q == N_TOT - 1);

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst) begin
            in_cnt_q  <= 0;
            out_pos_q <= 0;
            occ_q     <= 0;
        end else begin
            if (in_fire) in_cnt_q <= sym_in ? 0 : in_cnt_q + 1;
            if (out_fire) out_pos_q <= sym_out ? 0 : out_pos_q + 1;
            occ_q <= occ_q + (sym_in ? 1 : 0) - (sym_out ? 1 : 0);
        end
    end

    // R8: the cycle after reset shows an empty block.
    always_ff @(posedge clk) begin
        if (rst_seen_q && !rst) begin
            a_reset_empty_r8: assert (!out_valid && in_ready)
                else $error("reset did not empty the buffer");
        end
    end

    p_sos_pos_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_sos == (out_pos_q == 0)));

    p_last_pos_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (out_pos_q == N_TOT - 1)));

    p_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (occ_q == 0) |-> !out_valid);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (occ_q == 2) |-> !in_ready);

    p_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        (occ_q < 2) |-> in_ready);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)
                                       && $stable(out_sos) && $stable(out_last)));

endmodule

bind cp_insert cp_insert_chk #(.DW(DW), .N_FFT(N_FFT), .N_CP(N_CP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_re   (out_re),
    .out_im   (out_im),
    .out_sos  (out_sos),
    .out_last (out_last)
);

// File: tb/cp_insert_tb.sv
module cp_insert_tb;

    localparam int DW    = 16;
    localparam int N_FFT = 64;
    localparam int N_CP  = 16;
    localparam int N_TOT = N_FFT + N_CP;
    localparam int SW    = 2 * DW;
    localparam int LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0, in_ready;
    logic [DW-1:0] in_re = '0, in_im = '0;
    logic          out_valid, out_ready = 1'b0;
    logic [DW-1:0] out_re, out_im;
    logic          out_sos, out_last;

    always #2 clk = ~clk;

    cp_insert #(.DW(DW), .N_FFT(N_FFT), .N_CP(N_CP)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
        .out_sos(out_sos), .out_last(out_last)
    );

    int checks = 0, fails = 0, cycles = 0;
    bit timed_out = 0;
    bit phase_fill = 0;
    logic [SW-1:0] sb[$];
    logic [SW-1:0] cur [N_FFT];
    int in_cnt = 0, out_pos = 0, acc_total = 0, sym_in = 0, sym_out = 0;
    bit prev_stall = 0;
    logic [SW+1:0] prev_snap;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected extended symbol: tail first, then whole symbol.
    function automatic void push_expected();
        for (int k = 0; k < N_CP; k++) sb.push_back(cur[N_FFT - N_CP + k]);
        for (int k = 0; k < N_FFT; k++) sb.push_back(cur[k]);
    endfunction

    task automatic monitor();
        logic [SW-1:0] exp_d;
        if (rst) return;
        if (prev_stall)
            chk(out_valid && ({out_sos, out_last, out_re, out_im} == prev_snap),
                "R6", "stalled output changed", {out_valid, out_sos, out_last, out_re, out_im},
                {1'b1, prev_snap});
        if (phase_fill) begin
            chk(out_valid == (acc_total >= N_FFT), "R4", "out_valid vs captured count",
                out_valid, acc_total >= N_FFT);
            if (acc_total < 2 * N_FFT)
                chk(in_ready == 1'b1, "R7", "in_ready with a free bank", in_ready, 1);
            else
                chk(in_ready == 1'b0, "R5", "in_ready with both banks full", in_ready, 0);
        end
        if (out_valid && out_ready) begin
            if (sb.size() == 0) begin
                chk(0, "R9", "output with no captured symbol", {out_re, out_im}, 0);
            end else begin
                exp_d = sb.pop_front();
                chk({out_re, out_im} == exp_d, (out_pos < N_CP) ? "R2" : "R3",
                    $sformatf("data at pos %0d", out_pos), {out_re, out_im}, exp_d);
                chk(out_sos == (out_pos == 0), "R1", "sos flag", out_sos, out_pos == 0);
                chk(out_last == (out_pos == N_TOT - 1), "R1", "last flag", out_last,
                    out_pos == N_TOT - 1);
            end
            out_pos++;
            if (out_pos == N_TOT) begin
                out_pos = 0;
                sym_out++;
            end
        end
        if (in_valid && in_ready) begin
            cur[in_cnt] = {in_re, in_im};
            in_cnt++;
            acc_total++;
            if (in_cnt == N_FFT) begin
                push_expected();
                in_cnt = 0;
                sym_in++;
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_snap  = {out_sos, out_last, out_re, out_im};
    endtask

    task automatic step(input bit iv, input bit ordy);
        @(negedge clk);
        cycles++;
        if (cycles > LIMIT && !timed_out) begin
            timed_out = 1;
            chk(0, "R9", "watchdog expired", cycles, LIMIT);
        end
        in_valid  = iv;
        in_re     = DW'($urandom);
        in_im     = DW'($urandom);
        out_ready = ordy;
        #1;
        monitor();
    endtask

    task automatic clear_model();
        sb.delete();
        in_cnt = 0; out_pos = 0; acc_total = 0; sym_in = 0; sym_out = 0;
        prev_stall = 0;
    endtask

    task automatic drain();
        while (sb.size() != 0 && !timed_out) step(0, 1);
        step(0, 1);
        chk(sym_out == sym_in, "R9", "symbols out vs in", sym_out, sym_in);
        chk(!out_valid, "R4", "out_valid after drain", out_valid, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        // Reset state.
        rst = 1'b1;
        repeat (3) step(0, 0);
        rst = 1'b0;
        step(0, 0);
        chk(!out_valid, "R4", "out_valid after reset", out_valid, 0);
        chk(in_ready, "R8", "in_ready after reset", in_ready, 1);

        // Fill both banks with output held off.
        phase_fill = 1;
        while (acc_total < 2 * N_FFT && !timed_out) step(1, 0);
        repeat (4) step(1, 0);
        phase_fill = 0;
        chk(!in_ready, "R5", "input held while full", in_ready, 0);
        chk(acc_total == 2 * N_FFT, "R5", "accepted count while full", acc_total, 2 * N_FFT);
        drain();

        // Random density patterns: {input %, output %}.
        for (int p = 0; p < 4; p++) begin
            int pin, pout, target;
            pin  = (p == 0) ? 100 : (p == 1) ? 30 : (p == 2) ? 100 : 60;
            pout = (p == 0) ? 100 : (p == 1) ? 100 : (p == 2) ? 30 : 60;
            target = sym_out + 6;
            while (sym_out < target && !timed_out)
                step(($urandom % 100) < pin, ($urandom % 100) < pout);
            drain();
        end

        // Reset in mid-stream.
        repeat (100) step(1, 1);
        rst = 1'b1;
        step(0, 0);
        step(0, 0);
        rst = 1'b0;
        clear_model();
        step(0, 0);
        chk(!out_valid, "R8", "out_valid after mid-stream reset", out_valid, 0);
        chk(in_ready, "R8", "in_ready after mid-stream reset", in_ready, 1);
        while (sym_in < 1 && !timed_out) step(1, 0);
        drain();
        chk(sym_out == 1, "R8", "one clean symbol after reset", sym_out, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule